// File: doc/BRIEF.md
# Horner-Step Fixed-Point MAC Coprocessor

This block is an arithmetic coprocessor for a small processor with an 8-bit data bus. Software loads three operand registers and can also load the two result registers. It then writes a 4-bit operation code to a command address. One command runs an addition, a subtraction, a multiplication or a fused multiply-add. The operands are routed from any of the five registers through selectors in front of the multiplier and the adder. The product lands in the product register (M). Every sum or difference lands in the accumulator register (Z).

All arithmetic is signed two's-complement with 16 integer and 16 fractional bits. Each operation takes a fixed number of cycles, and a status bit reports busy while it runs. The main use is evaluating a polynomial. The evaluation point stays in A and the running value stays in Z. Before each further Horner step (Z ← Z×A + C), only the next coefficient is rewritten into C.

Top module: `mac_copro`

## Requirements
- R1: The active-low asynchronous reset clears A, B, C, M and Z to zero and drops busy.
- R2: Every 32-bit register sits on four consecutive byte addresses, least significant byte first. The bases are A at 0x00, B at 0x04, C at 0x08, M at 0x0C and Z at 0x10. All five registers can be written and read back byte by byte. Unmapped addresses read as zero.
- R3: Codes 0 to 5 write Z with, in that order: B+C, B−C, Z+C, Z−C, M+C and M−C.
- R4: Codes 6 to 8 write M with A×B, M×B and Z×A. The 64-bit product is shifted right arithmetically by 16 and its low 32 bits are kept. Truncation therefore rounds toward minus infinity.
- R5: Codes 9 to 12 write Z with A×B+C, A×B−C, Z+A×B and Z×A+C. The product term is truncated as in R4.
- R6: A command is a write of the code to bits 3:0 at address 0x14. Suppose that write is sampled at clock edge k. Then busy is high after edges k to k+5, and the status byte at 0x15 shows busy in bit 0. The target register keeps its old value through edge k+5. It takes the new value at edge k+6, and busy drops at that same edge.
- R7: A command written while busy is ignored. It neither changes the result nor extends the busy period.
- R8: Operands are captured at the command edge. Rewriting A, B or C while busy does not change the running operation.
- R9: Codes 13 to 15 start nothing: busy stays low and M and Z are unchanged.
- R10: Results wrap modulo 2^32 on overflow.
- R11: Loading A once and rewriting only C between successive code-12 commands evaluates a polynomial by Horner's rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Byte write strobe |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| busy_o | output | 1 | Operation in flight |

## Verification
The hard situations are the ones where the bus and the pipeline overlap. One is a second command arriving while an operation is in flight. Another is operands being overwritten before the result commits. A third is a result appearing one cycle too early or too late. From the ports these show up only as timing differences. The stimulus therefore issues a second command on the cycle right after launch. It rewrites all three operands through twelve byte writes during a multiply-add. After every command it samples busy, the status byte and the target register at each cycle of the window. The first stimulus also preloads M and Z with nonzero values, so that the recursive codes act on known state.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {SRC_A, SRC_B, SRC_C, SRC_M, SRC_Z, SRC_P} src_e;
  typedef enum logic [1:0] {DST_NONE, DST_M, DST_Z} dst_e;

  typedef struct packed {
    logic valid;
    src_e mul_a;
    src_e mul_b;
    src_e add_x;
    src_e add_y;
    logic sub;
    dst_e dst;
  } ctl_t;

  localparam int NREG  = 5;
  localparam int REG_A = 0;
  localparam int REG_B = 1;
  localparam int REG_C = 2;
  localparam int REG_M = 3;
  localparam int REG_Z = 4;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [3:0] op_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o.valid = 1'b1;
    ctl_o.mul_a = SRC_A;
    ctl_o.mul_b = SRC_B;
    ctl_o.add_x = SRC_B;
    ctl_o.add_y = SRC_C;
    ctl_o.sub   = 1'b0;
    ctl_o.dst   = DST_Z;
    case (op_i)
      4'd0: ;
      4'd1: ctl_o.sub = 1'b1;
      4'd2: ctl_o.add_x = SRC_Z;
      4'd3: begin ctl_o.add_x = SRC_Z; ctl_o.sub = 1'b1; end
      4'd4: ctl_o.add_x = SRC_M;
      4'd5: begin ctl_o.add_x = SRC_M; ctl_o.sub = 1'b1; end
      4'd6: ctl_o.dst = DST_M;
      4'd7: begin ctl_o.mul_a = SRC_M; ctl_o.dst = DST_M; end
      4'd8: begin ctl_o.mul_a = SRC_Z; ctl_o.mul_b = SRC_A; ctl_o.dst = DST_M; end
      4'd9: ctl_o.add_x = SRC_P;
      4'd10: begin ctl_o.add_x = SRC_P; ctl_o.sub = 1'b1; end
      4'd11: begin ctl_o.add_x = SRC_P; ctl_o.add_y = SRC_Z; end
      4'd12: begin
        ctl_o.mul_a = SRC_Z;
        ctl_o.mul_b = SRC_A;
        ctl_o.add_x = SRC_P;
      end
      default: begin
        ctl_o.valid = 1'b0;
        ctl_o.dst   = DST_NONE;
      end
    endcase
  end
endmodule

// File: rtl/mac_regs.sv
module mac_regs
  import mac_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          busy_i,
  input  logic          commit_i,
  input  dst_e          cdst_i,
  input  logic [DW-1:0] cres_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] c_o,
  output logic [DW-1:0] m_o,
  output logic [DW-1:0] z_o,
  output logic          ctrl_we_o,
  output logic [7:0]    rdata_o
);
  localparam int NB        = DW / 8;
  localparam int CTRL_ADDR = NREG * NB;
  localparam int STAT_ADDR = CTRL_ADDR + 1;

  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        // a committing result wins over a same-cycle bus write
        if (commit_i && ((r == REG_M && cdst_i == DST_M) ||
                         (r == REG_Z && cdst_i == DST_Z))) begin
          regs_q[r] <= cres_i;
        end else begin
          for (int b = 0; b < NB; b++)
            if (we_i && addr_i == AW'(r * NB + b)) regs_q[r][b*8 +: 8] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < NB; b++)
        if (addr_i == AW'(r * NB + b)) rdata_o = regs_q[r][b*8 +: 8];
    if (addr_i == AW'(STAT_ADDR)) rdata_o = {7'b0, busy_i};
  end

  assign a_o       = regs_q[REG_A];
  assign b_o       = regs_q[REG_B];
  assign c_o       = regs_q[REG_C];
  assign m_o       = regs_q[REG_M];
  assign z_o       = regs_q[REG_Z];
  assign ctrl_we_o = we_i && addr_i == AW'(CTRL_ADDR);

  logic m_bus_wr;
  assign m_bus_wr = we_i && addr_i >= AW'(REG_M * NB) && addr_i < AW'(REG_M * NB + NB);

  // R9: M only moves on a bus write or a product commit
  a_r9_m_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m_bus_wr && !(commit_i && cdst_i == DST_M)) |=> $stable(m_o));
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FRAC   = 16,
  parameter int STAGES = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  ctl_t          ctl_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  input  logic [DW-1:0] m_i,
  input  logic [DW-1:0] z_i,
  output logic          commit_o,
  output dst_e          dst_o,
  output logic [DW-1:0] res_o,
  output logic          busy_o
);
  localparam int DLY = STAGES - 3;  // STAGES >= 4

  function automatic logic [DW-1:0] pick(src_e s, logic [DW-1:0] a, logic [DW-1:0] b,
                                         logic [DW-1:0] c, logic [DW-1:0] m, logic [DW-1:0] z);
    case (s)
      SRC_A:   return a;
      SRC_B:   return b;
      SRC_C:   return c;
      SRC_M:   return m;
      SRC_Z:   return z;
      default: return '0;
    endcase
  endfunction

  logic go, busy_q;
  assign go = launch_i && ctl_i.valid && !busy_q;

  // stage 1: operand capture
  logic          v1, px1, sub1;
  logic [DW-1:0] ma1, mb1, x1, y1;
  dst_e          dst1;
  // stage 2: product
  logic          v2, px2, sub2;
  logic [DW-1:0] prod2, x2, y2;
  dst_e          dst2;
  // stage 3: sum
  logic          v3;
  logic [DW-1:0] res3;
  dst_e          dst3;
  // alignment delay
  logic          dv_q   [DLY];
  logic [DW-1:0] dres_q [DLY];
  dst_e          ddst_q [DLY];

  logic signed [2*DW-1:0] full;
  logic [DW-1:0] opx, sum;
  assign full = $signed({{DW{ma1[DW-1]}}, ma1}) * $signed({{DW{mb1[DW-1]}}, mb1});
  assign opx  = px2 ? prod2 : x2;
  assign sum  = sub2 ? opx - y2 : opx + y2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; px1 <= 1'b0; sub1 <= 1'b0; dst1 <= DST_NONE;
      ma1 <= '0; mb1 <= '0; x1 <= '0; y1 <= '0;
      v2 <= 1'b0; px2 <= 1'b0; sub2 <= 1'b0; dst2 <= DST_NONE;
      prod2 <= '0; x2 <= '0; y2 <= '0;
      v3 <= 1'b0; res3 <= '0; dst3 <= DST_NONE;
      for (int i = 0; i < DLY; i++) begin
        dv_q[i] <= 1'b0; dres_q[i] <= '0; ddst_q[i] <= DST_NONE;
      end
    end else begin
      v1 <= go;
      if (go) begin
        ma1  <= pick(ctl_i.mul_a, a_i, b_i, c_i, m_i, z_i);
        mb1  <= pick(ctl_i.mul_b, a_i, b_i, c_i, m_i, z_i);
        x1   <= pick(ctl_i.add_x, a_i, b_i, c_i, m_i, z_i);
        y1   <= pick(ctl_i.add_y, a_i, b_i, c_i, m_i, z_i);
        px1  <= ctl_i.add_x == SRC_P;
        sub1 <= ctl_i.sub;
        dst1 <= ctl_i.dst;
      end
      v2 <= v1; prod2 <= DW'(full >>> FRAC);
      x2 <= x1; y2 <= y1; px2 <= px1; sub2 <= sub1; dst2 <= dst1;
      v3 <= v2; res3 <= (dst2 == DST_M) ? prod2 : sum; dst3 <= dst2;
      for (int i = 0; i < DLY; i++) begin
        dv_q[i]   <= (i == 0) ? v3   : dv_q[i-1];
        dres_q[i] <= (i == 0) ? res3 : dres_q[i-1];
        ddst_q[i] <= (i == 0) ? dst3 : ddst_q[i-1];
      end
    end
  end

  assign commit_o = dv_q[DLY-1];
  assign res_o    = dres_q[DLY-1];
  assign dst_o    = ddst_q[DLY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_q <= 1'b0;
    else if (go)       busy_q <= 1'b1;
    else if (commit_o) busy_q <= 1'b0;
  end
  assign busy_o = busy_q;

  logic [DLY-1:0] dv_vec;
  always_comb for (int i = 0; i < DLY; i++) dv_vec[i] = dv_q[i];

  // R7: at most one operation anywhere in the pipeline
  a_r7_single_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({v1, v2, v3, dv_vec}));
  // R6: launch raises busy, commit drops it
  a_r6_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> busy_o);
  a_r6_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o);
  a_r6_commit_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> busy_o);
endmodule

// File: rtl/mac_copro.sv
module mac_copro
  import mac_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FRAC   = 16,
  parameter int STAGES = 6,
  parameter int AW     = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          busy_o
);
  logic [DW-1:0] a, b, c, m, z, res;
  logic          ctrl_we, commit;
  dst_e          cdst;
  ctl_t          ctl;

  mac_regs #(.DW(DW), .AW(AW)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .busy_i(busy_o), .commit_i(commit), .cdst_i(cdst), .cres_i(res),
    .a_o(a), .b_o(b), .c_o(c), .m_o(m), .z_o(z),
    .ctrl_we_o(ctrl_we), .rdata_o
  );

  mac_decode i_decode (.op_i(wdata_i[3:0]), .ctl_o(ctl));

  mac_pipe #(.DW(DW), .FRAC(FRAC), .STAGES(STAGES)) i_pipe (
    .clk_i, .rst_ni, .launch_i(ctrl_we), .ctl_i(ctl),
    .a_i(a), .b_i(b), .c_i(c), .m_i(m), .z_i(z),
    .commit_o(commit), .dst_o(cdst), .res_o(res), .busy_o
  );

  // R9: an unused code never raises busy
  a_r9_bad_code_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && !ctl.valid && !busy_o) |=> !busy_o);
endmodule

// File: tb/test_mac_copro.sv
`timescale 1ns/100ps
module test_mac_copro;
  logic       clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o;

  localparam logic [4:0] A_B = 0, B_B = 4, C_B = 8, M_B = 12, Z_B = 16, CTRL = 20, STAT = 21;

  mac_copro i_mac_copro (.clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .busy_o);

  always #5 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  logic [31:0] sa, sb, sc, sm, sz;

  typedef struct { string req; logic [31:0] exp; logic to_z; } item_t;
  item_t sb_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr8(logic [4:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic wr32(logic [4:0] base, logic [31:0] v);
    for (int k = 0; k < 4; k++) wr8(base + 5'(k), v[k*8 +: 8]);
    case (base)
      A_B: sa = v; B_B: sb = v; C_B: sc = v; M_B: sm = v; default: sz = v;
    endcase
  endtask

  task automatic rd32(logic [4:0] base, output logic [31:0] v);
    for (int k = 0; k < 4; k++) begin
      addr_i = base + 5'(k); #0.5; v[k*8 +: 8] = rdata_o;
    end
  endtask

  function automatic logic [31:0] fmul(logic [31:0] x, logic [31:0] y);
    logic signed [63:0] p;
    p = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
    return p[47:16];
  endfunction

  function automatic logic [31:0] model(int op);
    case (op)
      0: return sb + sc;              1: return sb - sc;
      2: return sz + sc;              3: return sz - sc;
      4: return sm + sc;              5: return sm - sc;
      6: return fmul(sa, sb);         7: return fmul(sm, sb);
      8: return fmul(sz, sa);         9: return fmul(sa, sb) + sc;
      10: return fmul(sa, sb) - sc;   11: return sz + fmul(sa, sb);
      default: return fmul(sz, sa) + sc;
    endcase
  endfunction

  // monitor: pops the oldest expectation and compares the committed register
  task automatic monitor_pop();
    item_t it;
    logic [31:0] v;
    it = sb_q.pop_front();
    rd32(it.to_z ? Z_B : M_B, v);
    chk(it.req, v, it.exp);
    if (it.to_z) sz = it.exp; else sm = it.exp;
  endtask

  // driver: pushes expectation, issues command, watches the R6 window
  task automatic run_op(int op, string req);
    item_t it;
    logic [31:0] old, v;
    logic lat_ok;
    it.req = req; it.exp = model(op); it.to_z = !(op >= 6 && op <= 8);
    sb_q.push_back(it);
    old = it.to_z ? sz : sm;
    wr8(CTRL, 8'(op));
    lat_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (busy_o !== 1'b1) lat_ok = 1'b0;
      addr_i = STAT; #0.5;
      if (rdata_o !== 8'h01) lat_ok = 1'b0;
      rd32(it.to_z ? Z_B : M_B, v);
      if (v !== old) lat_ok = 1'b0;
      if (i < 5) @(negedge clk_i);
    end
    @(negedge clk_i);
    if (busy_o !== 1'b0) lat_ok = 1'b0;
    chk("R6 latency window", 32'(lat_ok), 32'd1);
    monitor_pop();
  endtask

  initial begin
    logic [31:0] v, zsave, msave;
    sa = 0; sb = 0; sc = 0; sm = 0; sz = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 busy", 32'(busy_o), 0);
    rd32(A_B, v); chk("R1 A", v, 0);
    rd32(M_B, v); chk("R1 M", v, 0);
    rd32(Z_B, v); chk("R1 Z", v, 0);

    // R2 byte map
    wr32(C_B, 32'h4433_2211);
    addr_i = C_B + 5'd1; #0.5; chk("R2 C byte1", 32'(rdata_o), 32'h22);
    addr_i = 5'd30; #0.5; chk("R2 unmapped", 32'(rdata_o), 0);
    wr8(A_B + 5'd3, 8'hA5); sa[31:24] = 8'hA5;
    rd32(A_B, v); chk("R2 A byte3", v, sa);

    // main ops, M and Z preloaded
    wr32(A_B, 32'h0003_4000);   // 3.25
    wr32(B_B, 32'hFFFE_8000);   // -1.5
    wr32(C_B, 32'h0000_C000);   // 0.75
    wr32(M_B, 32'h0002_0000);   // 2.0
    wr32(Z_B, 32'hFFFC_0000);   // -4.0
    rd32(M_B, v); chk("R2 M preload", v, 32'h0002_0000);
    for (int op = 0; op < 6; op++) run_op(op, $sformatf("R3 op%0d", op));
    for (int op = 6; op < 9; op++) run_op(op, $sformatf("R4 op%0d", op));
    for (int op = 9; op < 13; op++) run_op(op, $sformatf("R5 op%0d", op));

    // R4 truncation toward minus infinity: -1.5 * 2^-16 -> -2 lsb
    wr32(A_B, 32'hFFFE_8000); wr32(B_B, 32'h0000_0001);
    run_op(6, "R4 trunc");
    rd32(M_B, v); chk("R4 trunc const", v, 32'hFFFF_FFFE);

    // R10 wrap
    wr32(B_B, 32'h7FFF_8000); wr32(C_B, 32'h0001_0000);
    run_op(0, "R10 wrap");
    rd32(Z_B, v); chk("R10 wrap const", v, 32'h8000_8000);

    // R7 second command while busy is ignored
    wr32(B_B, 32'h0001_0000); wr32(C_B, 32'h0002_0000);
    wr8(CTRL, 8'd0);
    wr8(CTRL, 8'd2);
    repeat (4) @(negedge clk_i);
    chk("R7 busy before k+6", 32'(busy_o), 1);
    @(negedge clk_i);
    chk("R7 busy not extended", 32'(busy_o), 0);
    repeat (10) @(negedge clk_i);
    chk("R7 no second launch", 32'(busy_o), 0);
    rd32(Z_B, v); chk("R7 Z", v, 32'h0003_0000);
    sz = v;

    // R8 operands rewritten during flight
    wr32(A_B, 32'h0002_0000); wr32(B_B, 32'h0003_0000); wr32(C_B, 32'h0000_8000);
    wr8(CTRL, 8'd9);
    wr32(A_B, 32'h0010_0000); wr32(B_B, 32'h0010_0000); wr32(C_B, 32'h0010_0000);
    repeat (2) @(negedge clk_i);
    rd32(Z_B, v); chk("R8 captured operands", v, 32'h0006_8000);
    sz = v;

    // R9 unused codes
    rd32(M_B, msave); rd32(Z_B, zsave);
    for (int op = 13; op < 16; op++) begin
      wr8(CTRL, 8'(op));
      chk($sformatf("R9 busy op%0d", op), 32'(busy_o), 0);
    end
    repeat (8) @(negedge clk_i);
    rd32(M_B, v); chk("R9 M unchanged", v, msave);
    rd32(Z_B, v); chk("R9 Z unchanged", v, zsave);

    // R11 Horner: 2x^3 - 3x^2 + 0.5x + 1 at x = 1.5 -> 1.75
    wr32(A_B, 32'h0001_8000);
    wr32(Z_B, 32'h0002_0000);
    wr32(C_B, 32'hFFFD_0000); run_op(12, "R11 step1");
    wr32(C_B, 32'h0000_8000); run_op(12, "R11 step2");
    wr32(C_B, 32'h0001_0000); run_op(12, "R11 step3");
    rd32(Z_B, v); chk("R11 p(x)", v, 32'h0001_C000);

    // R1 asynchronous reset mid-run
    wr8(CTRL, 8'd0);
    #2 rst_ni = 1'b0; #1;
    chk("R1 async busy", 32'(busy_o), 0);
    rd32(Z_B, v); chk("R1 async Z", v, 0);
    rd32(A_B, v); chk("R1 async A", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule